// File: doc/BRIEF.md
# Load/Store Bus Access Stage

This block is the memory-access stage of a three-stage fetch/decode/execute core. It receives a load or store from the execute stage, forms the effective address with a combinational adder, and drives it straight onto a pipelined single-master data bus in the same cycle. The bus returns read data one cycle after the address phase. The block extends that data to the register width and presents it to the register write port. The write happens on the clock edge that closes the data phase.

A load costs two execute cycles. While its data phase is open, the next instruction is stalled for one cycle, unless that instruction is itself a memory access. In that case its address phase overlaps the open data phase, so a run of N loads costs N+1 cycles. A one-entry write buffer holds a store's write data for its data phase, which lets the store retire after one cycle. A parameter removes the buffer; stores then cost two cycles, the same as loads. Bus wait states hold the outstanding address phase and stretch any stall one cycle per wait state.

Top module: `ldst_bus_unit`

## Requirements
- R1: While `req_valid_i` is high, `haddr_o` equals `req_base_i` plus `req_index_i` when `req_use_index_i` is 1, or `req_base_i` plus `req_imm_i` otherwise, in that same cycle, and `htrans_o` is 2'b10 (non-sequential). Without a request, `htrans_o` is 2'b00 (idle).
- R2: A single load followed by a non-memory instruction takes 2 cycles with no wait states: it is accepted in its first cycle, and `stall_o` is high for exactly the next cycle.
- R3: The cycle in which a load's data phase ends with `hready_i` high carries `rf_we_o`=1, `rf_waddr_o` equal to the load's `req_rd_i`, and the returned data. Every accepted load produces exactly one such write, in issue order.
- R4: A memory request presented during a load's data phase is accepted in that cycle without a stall. N consecutive loads take N+1 cycles with no wait states.
- R5: With `WBUF_EN`=1, a store is accepted in one cycle and does not stall a following non-memory instruction. Its write data appears on `hwdata_o` in the next cycle.
- R6: With `WBUF_EN`=0, a store followed by a non-memory instruction takes 2 cycles, with `stall_o` high in the cycle after acceptance.
- R7: While `hready_i` is low, a presented request is not accepted, `stall_o` stays high, and the address-phase outputs hold their values. Each wait state adds one stall cycle.
- R8: `req_size_i` encodes 00 byte, 01 halfword and 10 word. Memory is little-endian: the byte lane is `haddr[1:0]` and the halfword lane is `haddr[1]`. A load is zero-extended, or sign-extended when `req_signed_i` is 1.
- R9: Store data is replicated across the bus lanes: a byte into all four byte lanes and a halfword into both halfword lanes.
- R10: After reset, `htrans_o` is idle and `stall_o` and `rf_we_o` are low.
- R11: A non-memory instruction is not stalled while a buffered store's data phase is waiting on `hready_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Memory access in execute this cycle |
| req_write_i | input | 1 | 1 = store, 0 = load |
| req_size_i | input | 2 | Access size: 00 byte, 01 half, 10 word |
| req_signed_i | input | 1 | Sign-extend load data |
| req_use_index_i | input | 1 | Offset taken from index register instead of immediate |
| req_base_i | input | AW | Base register value |
| req_index_i | input | AW | Index register value |
| req_imm_i | input | AW | Immediate offset, already extended |
| req_wdata_i | input | DW | Store data, right-aligned |
| req_rd_i | input | RW | Load destination register |
| stall_o | output | 1 | Hold the instruction in execute |
| rf_we_o | output | 1 | Register write enable |
| rf_waddr_o | output | RW | Register write index |
| rf_wdata_o | output | DW | Extended load data |
| haddr_o | output | AW | Bus address |
| htrans_o | output | 2 | Bus transfer type: 00 idle, 10 non-sequential |
| hwrite_o | output | 1 | Bus write flag |
| hsize_o | output | 3 | Bus transfer size |
| hwdata_o | output | DW | Bus write data |
| hrdata_i | input | DW | Bus read data |
| hready_i | input | 1 | Bus data phase completes this cycle |

## Verification
The internal state is the single data-phase record. An error in it is visible at the ports one cycle after the request that loaded it. A lost or spurious pending flag shows up as a stall count that differs from 2, N+1 or 1 cycles. A wrong destination or lane shows up as a wrong `rf_waddr_o` or `rf_wdata_o` on the write-back cycle. A stale buffered store shows up as a wrong value on a later load of the same word. Random wait states push every one of these effects out by the number of stretched cycles, but no later.

// File: rtl/ldst_pkg.sv
package ldst_pkg;
  localparam logic [1:0] SZ_B = 2'd0;
  localparam logic [1:0] SZ_H = 2'd1;
  localparam logic [1:0] SZ_W = 2'd2;

  typedef enum logic [1:0] {
    TR_IDLE   = 2'b00,
    TR_NONSEQ = 2'b10
  } trans_e;
endpackage

// File: rtl/ldst_agu.sv
module ldst_agu #(
  parameter int AW = 32
) (
  input  logic [AW-1:0] base_i,
  input  logic [AW-1:0] index_i,
  input  logic [AW-1:0] imm_i,
  input  logic          use_index_i,
  output logic [AW-1:0] addr_o
);
  logic [AW-1:0] ofs;
  assign ofs    = use_index_i ? index_i : imm_i;
  assign addr_o = base_i + ofs;
endmodule

// File: rtl/ldst_dphase.sv
module ldst_dphase #(
  parameter int DW = 32,
  parameter int RW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          adv_i,
  input  logic          issue_i,
  input  logic          write_i,
  input  logic [1:0]    size_i,
  input  logic          sgn_i,
  input  logic [1:0]    alo_i,
  input  logic [RW-1:0] rd_i,
  input  logic [DW-1:0] wdata_i,
  output logic          pend_o,
  output logic          write_o,
  output logic [1:0]    size_o,
  output logic          sgn_o,
  output logic [1:0]    alo_o,
  output logic [RW-1:0] rd_o,
  output logic [DW-1:0] wdata_o
);
  // record only moves when the bus accepts a new address phase
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_o  <= 1'b0;
      write_o <= 1'b0;
      size_o  <= 2'd0;
      sgn_o   <= 1'b0;
      alo_o   <= 2'd0;
      rd_o    <= '0;
      wdata_o <= '0;
    end else if (adv_i) begin
      pend_o <= issue_i;
      if (issue_i) begin
        write_o <= write_i;
        size_o  <= size_i;
        sgn_o   <= sgn_i;
        alo_o   <= alo_i;
        rd_o    <= rd_i;
        wdata_o <= wdata_i;
      end
    end
  end
endmodule

// File: rtl/ldst_ldext.sv
module ldst_ldext
  import ldst_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [DW-1:0] rdata_i,
  input  logic [1:0]    alo_i,
  input  logic [1:0]    size_i,
  input  logic          sgn_i,
  output logic [DW-1:0] data_o
);
  logic [DW-1:0] sh;
  assign sh = rdata_i >> {alo_i, 3'b000};

  always_comb begin
    unique case (size_i)
      SZ_B:    data_o = {{(DW-8){sgn_i & sh[7]}}, sh[7:0]};
      SZ_H:    data_o = {{(DW-16){sgn_i & sh[15]}}, sh[15:0]};
      default: data_o = rdata_i;
    endcase
  end
endmodule

// File: rtl/ldst_bus_unit.sv
module ldst_bus_unit
  import ldst_pkg::*;
#(
  parameter int AW      = 32,
  parameter int DW      = 32,
  parameter int RW      = 4,
  parameter int WBUF_EN = 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  input  logic          req_write_i,
  input  logic [1:0]    req_size_i,
  input  logic          req_signed_i,
  input  logic          req_use_index_i,
  input  logic [AW-1:0] req_base_i,
  input  logic [AW-1:0] req_index_i,
  input  logic [AW-1:0] req_imm_i,
  input  logic [DW-1:0] req_wdata_i,
  input  logic [RW-1:0] req_rd_i,
  output logic          stall_o,
  output logic          rf_we_o,
  output logic [RW-1:0] rf_waddr_o,
  output logic [DW-1:0] rf_wdata_o,
  output logic [AW-1:0] haddr_o,
  output logic [1:0]    htrans_o,
  output logic          hwrite_o,
  output logic [2:0]    hsize_o,
  output logic [DW-1:0] hwdata_o,
  input  logic [DW-1:0] hrdata_i,
  input  logic          hready_i
);
  localparam int NB = DW / 8;
  localparam int NH = DW / 16;

  logic [AW-1:0] ea;
  logic          issue;
  logic [DW-1:0] wrep;
  logic          dp_pend, dp_write, dp_sgn, dp_blocks;
  logic [1:0]    dp_size, dp_alo;
  logic [RW-1:0] dp_rd;
  logic [DW-1:0] dp_wdata;

  ldst_agu #(.AW(AW)) u_agu (
    .base_i      (req_base_i),
    .index_i     (req_index_i),
    .imm_i       (req_imm_i),
    .use_index_i (req_use_index_i),
    .addr_o      (ea)
  );

  // address phase is combinational from execute
  assign issue    = req_valid_i & hready_i;
  assign haddr_o  = req_valid_i ? ea : '0;
  assign htrans_o = req_valid_i ? TR_NONSEQ : TR_IDLE;
  assign hwrite_o = req_valid_i & req_write_i;
  assign hsize_o  = {1'b0, req_size_i};

  always_comb begin
    unique case (req_size_i)
      SZ_B:    wrep = {NB{req_wdata_i[7:0]}};
      SZ_H:    wrep = {NH{req_wdata_i[15:0]}};
      default: wrep = req_wdata_i;
    endcase
  end

  ldst_dphase #(.DW(DW), .RW(RW)) u_dp (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .adv_i   (hready_i),
    .issue_i (issue),
    .write_i (req_write_i),
    .size_i  (req_size_i),
    .sgn_i   (req_signed_i),
    .alo_i   (ea[1:0]),
    .rd_i    (req_rd_i),
    .wdata_i (wrep),
    .pend_o  (dp_pend),
    .write_o (dp_write),
    .size_o  (dp_size),
    .sgn_o   (dp_sgn),
    .alo_o   (dp_alo),
    .rd_o    (dp_rd),
    .wdata_o (dp_wdata)
  );

  generate
    if (WBUF_EN != 0) begin : g_wbuf
      assign dp_blocks = dp_pend & ~dp_write;
    end else begin : g_nowbuf
      assign dp_blocks = dp_pend;
    end
  endgenerate

  // stall: request blocked by wait state, or open data phase not overlapped
  assign stall_o = (req_valid_i & ~hready_i) | (dp_blocks & ~issue);

  assign hwdata_o   = (dp_pend & dp_write) ? dp_wdata : '0;
  assign rf_we_o    = dp_pend & ~dp_write & hready_i;
  assign rf_waddr_o = dp_rd;

  ldst_ldext #(.DW(DW)) u_ext (
    .rdata_i (hrdata_i),
    .alo_i   (dp_alo),
    .size_i  (dp_size),
    .sgn_i   (dp_sgn),
    .data_o  (rf_wdata_o)
  );
endmodule

// File: rtl/ldst_bus_unit_chk.sv
module ldst_bus_unit_chk #(
  parameter int AW      = 32,
  parameter int DW      = 32,
  parameter int RW      = 4,
  parameter int WBUF_EN = 1
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          req_valid_i,
  input logic          req_use_index_i,
  input logic [AW-1:0] req_base_i,
  input logic [AW-1:0] req_index_i,
  input logic [AW-1:0] req_imm_i,
  input logic          stall_o,
  input logic          rf_we_o,
  input logic [AW-1:0] haddr_o,
  input logic [1:0]    htrans_o,
  input logic          hwrite_o,
  input logic          hready_i
);
  // R1
  addr_gen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |-> haddr_o == (req_base_i + (req_use_index_i ? req_index_i : req_imm_i)));

  // R1
  idle_trans_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |-> htrans_o == 2'b00);

  // R2
  load_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (htrans_o == 2'b10 && !hwrite_o && hready_i) |=> (stall_o || (req_valid_i && hready_i)));

  // R3
  load_wb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (htrans_o == 2'b10 && !hwrite_o && hready_i) |=> (rf_we_o == hready_i));

  // R3
  wb_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rf_we_o |-> hready_i);

  // R5
  store_retire_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (WBUF_EN != 0 && htrans_o == 2'b10 && hwrite_o && hready_i) |=> (!stall_o || req_valid_i));

  // R7
  addr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (htrans_o == 2'b10 && !hready_i) |=> (htrans_o == 2'b10 && $stable(haddr_o) && $stable(hwrite_o)));
endmodule

bind ldst_bus_unit ldst_bus_unit_chk #(.AW(AW), .DW(DW), .RW(RW), .WBUF_EN(WBUF_EN)) u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .req_valid_i     (req_valid_i),
  .req_use_index_i (req_use_index_i),
  .req_base_i      (req_base_i),
  .req_index_i     (req_index_i),
  .req_imm_i       (req_imm_i),
  .stall_o         (stall_o),
  .rf_we_o         (rf_we_o),
  .haddr_o         (haddr_o),
  .htrans_o        (htrans_o),
  .hwrite_o        (hwrite_o),
  .hready_i        (hready_i)
);

// File: tb/sim_ldst_bus_unit.sv
module sim_ldst_bus_unit;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        r_valid = 0, r_write = 0, r_sgn = 0, r_ui = 0;
  logic [1:0]  r_size = 0;
  logic [31:0] r_base = 0, r_index = 0, r_imm = 0, r_wdata = 0;
  logic [3:0]  r_rd = 0;
  logic        v1 = 0;

  logic        stall, rf_we, hwrite, hready;
  logic [3:0]  rf_waddr;
  logic [31:0] rf_wdata, haddr, hwdata, hrdata;
  logic [1:0]  htrans;
  logic [2:0]  hsize;

  logic        stall1, rf_we1, hwrite1;
  logic [3:0]  rf_waddr1;
  logic [31:0] rf_wdata1, haddr1, hwdata1;
  logic [1:0]  htrans1;
  logic [2:0]  hsize1;

  ldst_bus_unit u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(r_valid), .req_write_i(r_write),
    .req_size_i(r_size), .req_signed_i(r_sgn), .req_use_index_i(r_ui),
    .req_base_i(r_base), .req_index_i(r_index), .req_imm_i(r_imm),
    .req_wdata_i(r_wdata), .req_rd_i(r_rd), .stall_o(stall), .rf_we_o(rf_we),
    .rf_waddr_o(rf_waddr), .rf_wdata_o(rf_wdata), .haddr_o(haddr),
    .htrans_o(htrans), .hwrite_o(hwrite), .hsize_o(hsize), .hwdata_o(hwdata),
    .hrdata_i(hrdata), .hready_i(hready)
  );

  ldst_bus_unit #(.WBUF_EN(0)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(v1), .req_write_i(r_write),
    .req_size_i(r_size), .req_signed_i(r_sgn), .req_use_index_i(r_ui),
    .req_base_i(r_base), .req_index_i(r_index), .req_imm_i(r_imm),
    .req_wdata_i(r_wdata), .req_rd_i(r_rd), .stall_o(stall1), .rf_we_o(rf_we1),
    .rf_waddr_o(rf_waddr1), .rf_wdata_o(rf_wdata1), .haddr_o(haddr1),
    .htrans_o(htrans1), .hwrite_o(hwrite1), .hsize_o(hsize1), .hwdata_o(hwdata1),
    .hrdata_i(32'h0), .hready_i(1'b1)
  );

  int checks = 0;
  int errors = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] init_word(input int i);
    return (32'(i) * 32'h0103_0507) ^ 32'hA5C3_0F1E;
  endfunction

  function automatic logic lane_on(input logic [1:0] alo, input logic [1:0] sz, input int b);
    if (sz == 2'd0) return 2'(b) == alo;
    if (sz == 2'd1) return 1'(b >> 1) == alo[1];
    return 1'b1;
  endfunction

  function automatic logic [31:0] exp_ext(input logic [31:0] w, input logic [1:0] alo,
                                          input logic [1:0] sz, input logic sg);
    logic [31:0] s;
    s = w >> (8 * alo);
    if (sz == 2'd0) return sg ? {{24{s[7]}}, s[7:0]} : {24'h0, s[7:0]};
    if (sz == 2'd1) return sg ? {{16{s[15]}}, s[15:0]} : {16'h0, s[15:0]};
    return w;
  endfunction

  // bus slave with wait states
  logic [31:0] mem [16];
  logic [31:0] ref_mem [16];
  logic        sl_pend, sl_wr;
  logic [31:0] sl_addr;
  logic [1:0]  sl_size;
  int          sl_wait;
  int          ws_mode = 0;

  function automatic int pick_wait();
    if (ws_mode == 0) return 0;
    if (ws_mode == 1) return int'($urandom_range(0, 2));
    return 2;
  endfunction

  assign hready = !(sl_pend && sl_wait != 0);
  assign hrdata = (sl_pend && !sl_wr) ? mem[sl_addr[5:2]] : 32'h0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sl_pend <= 1'b0; sl_wr <= 1'b0; sl_addr <= 0; sl_size <= 0; sl_wait <= 0;
      for (int i = 0; i < 16; i++) mem[i] <= init_word(i);
    end else if (hready) begin
      if (sl_pend && sl_wr)
        for (int b = 0; b < 4; b++)
          if (lane_on(sl_addr[1:0], sl_size, b)) mem[sl_addr[5:2]][b*8 +: 8] <= hwdata[b*8 +: 8];
      sl_pend <= (htrans == 2'b10);
      sl_addr <= haddr;
      sl_wr   <= hwrite;
      sl_size <= hsize[1:0];
      sl_wait <= pick_wait();
    end else begin
      sl_wait <= sl_wait - 1;
    end
  end

  // expected write-back queue
  logic [31:0] eq_d [64];
  logic [3:0]  eq_r [64];
  int eq_w = 0;
  int eq_p = 0;

  always @(negedge clk) begin
    #2;
    if (rst_n && rf_we) begin
      if (eq_p == eq_w) chk("R3 unexpected write", 32'd1, 32'd0);
      else begin
        chk("R8", rf_wdata, eq_d[eq_p % 64]);
        chk("R3", {28'h0, rf_waddr}, {28'h0, eq_r[eq_p % 64]});
        eq_p++;
      end
    end
  end

  task automatic do_op(input logic wr, input logic [1:0] sz, input logic sg,
                       input logic [31:0] a, input logic [31:0] wd, input logic [3:0] rd,
                       output int cyc);
    logic [31:0] b, junk;
    logic ui;
    b = $urandom;
    junk = $urandom;
    ui = 1'($urandom);
    cyc = 0;
    forever begin
      @(negedge clk);
      r_valid = 1; r_write = wr; r_size = sz; r_sgn = sg; r_ui = ui;
      r_base = b; r_index = ui ? a - b : junk; r_imm = ui ? junk : a - b;
      r_wdata = wd; r_rd = rd;
      #2;
      cyc++;
      chk(stall ? "R7" : "R1", haddr, a);
      chk("R1", {30'h0, htrans}, 32'd2);
      if (!stall) break;
    end
    if (wr) begin
      for (int k = 0; k < 4; k++)
        if (lane_on(a[1:0], sz, k))
          ref_mem[a[5:2]][k*8 +: 8] = (sz == 2'd0) ? wd[7:0] :
                                      (sz == 2'd1) ? wd[(k%2)*8 +: 8] : wd[k*8 +: 8];
    end else begin
      eq_d[eq_w % 64] = exp_ext(ref_mem[a[5:2]], a[1:0], sz, sg);
      eq_r[eq_w % 64] = rd;
      eq_w++;
    end
  endtask

  task automatic tail(output int cyc);
    cyc = 0;
    forever begin
      @(negedge clk);
      r_valid = 0;
      #2;
      if (!stall) break;
      cyc++;
    end
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      r_valid = 0;
    end
  endtask

  initial begin
    #(20 * 150000);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int c, t, tot;
    void'($urandom(32'd4242));
    for (int i = 0; i < 16; i++) ref_mem[i] = init_word(i);
    repeat (3) @(negedge clk);
    #2;
    // R10 reset state
    chk("R10", {30'h0, htrans}, 32'd0);
    chk("R10", {31'h0, stall}, 32'd0);
    chk("R10", {31'h0, rf_we}, 32'd0);
    rst_n = 1;
    idle(2);

    // R2 single load
    do_op(0, 2'd2, 0, 32'h04, 0, 4'd3, c); tail(t);
    chk("R2", c + t, 32'd2);
    idle(3);

    // R4 back-to-back and multiple loads
    for (int n = 2; n <= 5; n += 3) begin
      tot = 0;
      for (int k = 0; k < n; k++) begin
        do_op(0, 2'd2, 0, 32'(4 * k + 8), 0, 4'(k + 1), c); tot += c;
      end
      tail(t);
      chk("R4", tot + t, 32'(n + 1));
      idle(3);
    end

    // R5 R9 byte store, single cycle, replicated lanes
    do_op(1, 2'd0, 0, 32'h11, 32'h55AB, 4'd0, c);
    @(negedge clk); r_valid = 0; #2;
    chk("R9", hwdata, 32'hABAB_ABAB);
    chk("R5", c + 32'(stall), 32'd1);
    do_op(1, 2'd1, 0, 32'h22, 32'h9234, 4'd0, c);
    @(negedge clk); r_valid = 0; #2;
    chk("R9", hwdata, 32'h9234_9234);
    idle(2);

    // R8 extensions read back through loads
    do_op(1, 2'd0, 0, 32'h33, 32'h80, 4'd0, c);
    do_op(0, 2'd0, 1, 32'h33, 0, 4'd5, c);
    do_op(0, 2'd0, 0, 32'h33, 0, 4'd6, c);
    do_op(0, 2'd1, 1, 32'h22, 0, 4'd7, c);
    do_op(0, 2'd1, 0, 32'h22, 0, 4'd8, c);
    do_op(0, 2'd2, 0, 32'h10, 0, 4'd9, c);
    tail(t);
    idle(3);
    chk("R8", eq_d[(eq_w - 5) % 64], 32'hFFFF_FF80);

    // R11 R7 fixed two wait states
    ws_mode = 2;
    do_op(1, 2'd2, 0, 32'h3C, 32'h1357_9BDF, 4'd0, c); tail(t);
    chk("R11", c + t, 32'd1);
    idle(4);
    do_op(1, 2'd2, 0, 32'h38, 32'h2468_ACE0, 4'd0, c);
    do_op(0, 2'd2, 0, 32'h38, 0, 4'd10, c);
    chk("R7", c, 32'd3);
    tail(t);
    chk("R7", t, 32'd3);
    idle(4);

    // random mix with random wait states
    ws_mode = 1;
    for (int i = 0; i < 400; i++) begin
      logic [1:0] sz;
      logic [31:0] a;
      sz = 2'($urandom_range(0, 2));
      a = 32'($urandom_range(0, 63));
      if (sz == 2'd1) a[0] = 1'b0;
      if (sz == 2'd2) a[1:0] = 2'b00;
      do_op(1'($urandom), sz, 1'($urandom), a, $urandom, 4'($urandom_range(1, 15)), c);
      if ($urandom_range(0, 3) == 0) idle(int'($urandom_range(1, 2)));
    end
    ws_mode = 0;
    idle(8);
    chk("R3 all loads written", 32'(eq_p), 32'(eq_w));

    // R6 store without write buffer
    @(negedge clk); v1 = 1; r_write = 1; r_size = 2'd2; #2;
    chk("R6", {31'h0, stall1}, 32'd0);
    @(negedge clk); v1 = 0; #2;
    chk("R6", {31'h0, stall1}, 32'd1);
    @(negedge clk); #2;
    chk("R6", {31'h0, stall1}, 32'd0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule